// File: doc/BRIEF.md
# Serial Peripheral Host Controller with FIFO Watermark Interrupts

This block is a register-mapped host for a single serial peripheral. Software programs a clock divider, chip-select timing and two FIFO thresholds through a simple synchronous register port. Bytes written to the transmit data register are queued and shifted out full-duplex. The clock idles low, data changes on the falling edge and is sampled on the rising edge, and the most significant bit goes first. Each byte sent captures one byte from the peripheral into the receive queue. To read from a peripheral, software sends 0xFF filler bytes and then collects the captured bytes in order.

The chip-select line has several programmable delays, all counted in serial clock periods: a setup delay before the first clock edge, a hold delay after the last edge, a minimum deselected time between frames, and an optional pause between consecutive bytes while the select stays active. Two pending flags compare FIFO occupancy against the programmed thresholds. Each flag is masked by its own enable bit and the masked flags are combined into one interrupt line.

Register map (6-bit byte address): 0x00 divider; 0x04 select timing (setup in [7:0], hold in [15:8]); 0x08 frame spacing (deselect minimum in [7:0], active-select pause in [15:8]); 0x0C transmit data; 0x10 receive data; 0x14 transmit threshold; 0x18 receive threshold; 0x1C enable mask; 0x20 pending flags (read-only).

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset the divider reads 3, select timing reads 0x0101, frame spacing reads 0x0001, both thresholds, the enable mask and the pending flags read 0, cs_n is 1, sck is 0 and irq is 0.
- R2: While bytes are shifting, each high and low phase of sck lasts divider+1 clock cycles, so sck runs at the clock frequency divided by 2*(divider+1).
- R3: sck is low whenever cs_n is high. mosi changes only after a falling sck edge and carries each byte MSB first. miso is sampled on the rising sck edge.
- R4: Every byte sent pushes exactly one received byte into the 8-entry receive FIFO. A read of 0x10 returns the oldest byte in bits [7:0] with bit 31 clear, and removes it.
- R5: A read of 0x10 while the receive FIFO is empty returns bit 31 set and bits [7:0] zero, and removes nothing.
- R6: The transmit FIFO holds 8 entries. A write to 0x0C while it is full is discarded. Bit 31 of a read of 0x0C reports the full state.
- R7: The first rising sck edge of a frame follows the falling edge of cs_n by (2*setup+1)*(divider+1) clock cycles, where setup is nonzero.
- R8: cs_n stays low across consecutive bytes while the transmit FIFO still holds data. Once the FIFO has drained, cs_n rises 2*hold*(divider+1) cycles after the last falling sck edge (hold nonzero).
- R9: After cs_n rises it stays high for at least 2*deselect*(divider+1) cycles before the next frame begins.
- R10: Pending bit 0 is 1 exactly when the transmit FIFO holds fewer entries than the transmit threshold.
- R11: Pending bit 1 is 1 exactly when the receive FIFO holds more entries than the receive threshold.
- R12: irq is the OR over both bits of pending AND enable mask. Enable bit 0 gates transmit and bit 1 gates receive.
- R13: Between consecutive bytes with cs_n held low, sck stays low for (2*pause+1)*(divider+1) cycles after the last falling edge. With pause 0 this is one normal half period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive FIFO at 0x10) |
| reg_addr | input | 6 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the same cycle as reg_rd |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to the peripheral |
| miso | input | 1 | Serial data from the peripheral |
| irq | output | 1 | Masked watermark interrupt |

## Verification
Several properties are checked on every cycle. sck must be low while deselected, and mosi must not move during a high phase. FIFO occupancy must never pass the depth, and a full FIFO must refuse a write. The divider tick must never fire on two cycles in a row, and either enabled watermark condition must force irq. The timing of the delay sequencer can only be shown by the bench scenarios, which measure setup, hold, deselect time, inter-byte pause and half-period width in clock cycles. The same holds for byte order and full-duplex content through a modelled peripheral, the dropped write on overflow, and the pending flags after the FIFOs drain.

// File: rtl/spih_pkg.sv
package spih_pkg;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] A_DIV   = 6'h00;
  localparam logic [ADDR_W-1:0] A_CSDLY = 6'h04;
  localparam logic [ADDR_W-1:0] A_SPACE = 6'h08;
  localparam logic [ADDR_W-1:0] A_TXD   = 6'h0C;
  localparam logic [ADDR_W-1:0] A_RXD   = 6'h10;
  localparam logic [ADDR_W-1:0] A_TXLVL = 6'h14;
  localparam logic [ADDR_W-1:0] A_RXLVL = 6'h18;
  localparam logic [ADDR_W-1:0] A_IEN   = 6'h1C;
  localparam logic [ADDR_W-1:0] A_IPND  = 6'h20;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SHIFT,
    ST_GAP,
    ST_HOLD,
    ST_PAUSE
  } eng_state_t;
endpackage

// File: rtl/spih_fifo.sv
module spih_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             push,
  input  logic [WIDTH-1:0]                 wdata,
  input  logic                             pop,
  output logic [WIDTH-1:0]                 rdata,
  output logic                             full,
  output logic                             empty,
  output logic [$clog2(DEPTH+1)-1:0]       count
);
  localparam int AW    = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp_q, wp_d, rp_q, rp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign count   = cnt_q;
  assign rdata   = mem[rp_q];
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_push) wp_d = wp_q + 1'b1;
    if (do_pop)  rp_d = rp_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  assert_full_write_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (cnt_q == CNT_W'(DEPTH)));
endmodule

// File: rtl/spih_clkdiv.sv
module spih_clkdiv #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == div);

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0 && $stable(div)) |=> !tick);
endmodule

// File: rtl/spih_engine.sv
module spih_engine
  import spih_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             tx_valid,
  input  logic [7:0]       tx_data,
  input  logic [DLY_W-1:0] setup,
  input  logic [DLY_W-1:0] hold,
  input  logic [DLY_W-1:0] deselect,
  input  logic [DLY_W-1:0] pause,
  input  logic             miso,
  output logic             tx_pop,
  output logic             rx_push,
  output logic [7:0]       rx_byte,
  output logic             busy,
  output logic             sck,
  output logic             cs_n,
  output logic             mosi
);
  localparam int DC_W = DLY_W + 1;

  eng_state_t      state_q, state_d;
  logic [DC_W-1:0] dcnt_q, dcnt_d, dcnt_dec;
  logic            sck_q, sck_d, cs_n_q, cs_n_d;
  logic [7:0]      txsh_q, txsh_d, rxsh_q, rxsh_d;
  logic [2:0]      bit_q, bit_d;
  logic            go;

  assign go       = (dcnt_q == '0) || (tick && dcnt_q == DC_W'(1));
  assign dcnt_dec = tick ? dcnt_q - 1'b1 : dcnt_q;
  assign busy     = (state_q != ST_IDLE);
  assign sck      = sck_q;
  assign cs_n     = cs_n_q;
  assign mosi     = txsh_q[7];
  assign rx_byte  = rxsh_q;

  always_comb begin
    state_d = state_q;
    dcnt_d  = dcnt_q;
    sck_d   = sck_q;
    cs_n_d  = cs_n_q;
    txsh_d  = txsh_q;
    rxsh_d  = rxsh_q;
    bit_d   = bit_q;
    tx_pop  = 1'b0;
    rx_push = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (tx_valid) begin
          tx_pop  = 1'b1;
          txsh_d  = tx_data;
          cs_n_d  = 1'b0;
          bit_d   = '0;
          dcnt_d  = {setup, 1'b0};
          state_d = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (go) state_d = ST_SHIFT;
        else    dcnt_d  = dcnt_dec;
      end
      ST_SHIFT: begin
        if (tick) begin
          if (!sck_q) begin
            sck_d  = 1'b1;
            rxsh_d = {rxsh_q[6:0], miso};
          end else begin
            sck_d = 1'b0;
            if (bit_q == 3'd7) begin
              rx_push = 1'b1;
              bit_d   = '0;
              if (tx_valid && pause == '0) begin
                tx_pop = 1'b1;
                txsh_d = tx_data;
              end else if (tx_valid) begin
                dcnt_d  = {pause, 1'b0};
                state_d = ST_GAP;
              end else begin
                dcnt_d  = {hold, 1'b0};
                state_d = ST_HOLD;
              end
            end else begin
              bit_d  = bit_q + 1'b1;
              txsh_d = {txsh_q[6:0], 1'b0};
            end
          end
        end
      end
      ST_GAP: begin
        if (go) begin
          if (tx_valid) begin
            tx_pop  = 1'b1;
            txsh_d  = tx_data;
            state_d = ST_SHIFT;
          end else begin
            dcnt_d  = {hold, 1'b0};
            state_d = ST_HOLD;
          end
        end else begin
          dcnt_d = dcnt_dec;
        end
      end
      ST_HOLD: begin
        if (go) begin
          cs_n_d  = 1'b1;
          dcnt_d  = {deselect, 1'b0};
          state_d = ST_PAUSE;
        end else begin
          dcnt_d = dcnt_dec;
        end
      end
      ST_PAUSE: begin
        if (go) state_d = ST_IDLE;
        else    dcnt_d  = dcnt_dec;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dcnt_q  <= '0;
      sck_q   <= 1'b0;
      cs_n_q  <= 1'b1;
      txsh_q  <= '0;
      rxsh_q  <= '0;
      bit_q   <= '0;
    end else begin
      state_q <= state_d;
      dcnt_q  <= dcnt_d;
      sck_q   <= sck_d;
      cs_n_q  <= cs_n_d;
      txsh_q  <= txsh_d;
      rxsh_q  <= rxsh_d;
      bit_q   <= bit_d;
    end
  end

  assert_sck_idle_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_q |-> !sck_q);

  assert_mosi_stable_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_q && $past(sck_q)) |-> $stable(txsh_q[7]));
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
  import spih_pkg::*;
#(
  parameter int DIV_W = 12,
  parameter int DLY_W = 8,
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              sck,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso,
  output logic              irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DIV_W-1:0] div_q, div_d;
  logic [DLY_W-1:0] setup_q, setup_d, hold_q, hold_d;
  logic [DLY_W-1:0] desel_q, desel_d, pause_q, pause_d;
  logic [CNT_W-1:0] txmark_q, txmark_d, rxmark_q, rxmark_d;
  logic [1:0]       ie_q, ie_d, pend;

  logic             tx_push, tx_pop, tx_full, tx_empty;
  logic [7:0]       tx_head;
  logic [CNT_W-1:0] tx_cnt;
  logic             rx_push, rx_pop, rx_full, rx_empty;
  logic [7:0]       rx_in, rx_head;
  logic [CNT_W-1:0] rx_cnt;
  logic             tick, busy;

  assign tx_push = reg_wr && (reg_addr == A_TXD);
  assign rx_pop  = reg_rd && (reg_addr == A_RXD);
  assign pend    = {rx_cnt > rxmark_q, tx_cnt < txmark_q};
  assign irq     = |(pend & ie_q);

  always_comb begin
    div_d    = div_q;
    setup_d  = setup_q;
    hold_d   = hold_q;
    desel_d  = desel_q;
    pause_d  = pause_q;
    txmark_d = txmark_q;
    rxmark_d = rxmark_q;
    ie_d     = ie_q;
    if (reg_wr) begin
      case (reg_addr)
        A_DIV:   div_d = reg_wdata[DIV_W-1:0];
        A_CSDLY: begin
          setup_d = reg_wdata[DLY_W-1:0];
          hold_d  = reg_wdata[8 +: DLY_W];
        end
        A_SPACE: begin
          desel_d = reg_wdata[DLY_W-1:0];
          pause_d = reg_wdata[8 +: DLY_W];
        end
        A_TXLVL: txmark_d = reg_wdata[CNT_W-1:0];
        A_RXLVL: rxmark_d = reg_wdata[CNT_W-1:0];
        A_IEN:   ie_d = reg_wdata[1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= DIV_W'(3);
      setup_q  <= DLY_W'(1);
      hold_q   <= DLY_W'(1);
      desel_q  <= DLY_W'(1);
      pause_q  <= '0;
      txmark_q <= '0;
      rxmark_q <= '0;
      ie_q     <= '0;
    end else begin
      div_q    <= div_d;
      setup_q  <= setup_d;
      hold_q   <= hold_d;
      desel_q  <= desel_d;
      pause_q  <= pause_d;
      txmark_q <= txmark_d;
      rxmark_q <= rxmark_d;
      ie_q     <= ie_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_DIV:   reg_rdata[DIV_W-1:0] = div_q;
      A_CSDLY: begin
        reg_rdata[DLY_W-1:0] = setup_q;
        reg_rdata[8 +: DLY_W] = hold_q;
      end
      A_SPACE: begin
        reg_rdata[DLY_W-1:0] = desel_q;
        reg_rdata[8 +: DLY_W] = pause_q;
      end
      A_TXD:   reg_rdata[31] = tx_full;
      A_RXD: begin
        if (rx_empty) reg_rdata[31]  = 1'b1;
        else          reg_rdata[7:0] = rx_head;
      end
      A_TXLVL: reg_rdata[CNT_W-1:0] = txmark_q;
      A_RXLVL: reg_rdata[CNT_W-1:0] = rxmark_q;
      A_IEN:   reg_rdata[1:0] = ie_q;
      A_IPND:  reg_rdata[1:0] = pend;
      default: reg_rdata = '0;
    endcase
  end

  spih_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(reg_wdata[7:0]),
    .pop(tx_pop), .rdata(tx_head), .full(tx_full), .empty(tx_empty),
    .count(tx_cnt)
  );

  spih_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_in),
    .pop(rx_pop), .rdata(rx_head), .full(rx_full), .empty(rx_empty),
    .count(rx_cnt)
  );

  spih_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(div_q), .tick(tick)
  );

  spih_engine #(.DLY_W(DLY_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tx_valid(!tx_empty),
    .tx_data(tx_head), .setup(setup_q), .hold(hold_q), .deselect(desel_q),
    .pause(pause_q), .miso(miso), .tx_pop(tx_pop), .rx_push(rx_push),
    .rx_byte(rx_in), .busy(busy), .sck(sck), .cs_n(cs_n), .mosi(mosi)
  );

  assert_tx_mark_irq_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt < txmark_q && ie_q[0]) |-> irq);

  assert_rx_mark_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt > rxmark_q && ie_q[1]) |-> irq);

  assert_rx_full_unused_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> !rx_empty);
endmodule

// File: tb/sim_spi_host_ctrl.sv
module sim_spi_host_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd;
  logic [5:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        sck, cs_n, mosi, irq;
  logic        miso = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  int cyc = 0;

  logic [7:0] exp_mosi[$];
  logic [7:0] exp_rx[$];
  int n_acc = 0;

  spi_host_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso), .irq(irq)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] resp(input int k);
    return 8'(8'h5A ^ (k * 37));
  endfunction

  function automatic logic resp_bit(input int k, input int b);
    logic [7:0] r;
    r = resp(k);
    return r[b];
  endfunction

  // peripheral model: shifts in mosi on rising sck, drives miso after falling
  logic [7:0] s_sh = '0;
  int s_cnt = 0;
  int s_k = 0;

  always @(negedge cs_n) miso = resp_bit(s_k, 7);
  always @(negedge sck) if (!cs_n) miso = resp_bit(s_k, 7 - s_cnt);
  always @(posedge sck) begin
    logic [7:0] e;
    if (!cs_n) begin
      s_sh = {s_sh[6:0], mosi};
      s_cnt++;
      if (s_cnt == 8) begin
        s_cnt = 0;
        if (exp_mosi.size() > 0) begin
          e = exp_mosi.pop_front();
          check(s_sh == e, "R3 mosi byte MSB first", s_sh, e);
        end else begin
          check(1'b0, "R3 unexpected byte on mosi", s_sh, 0);
        end
        s_k++;
      end
    end
  end

  // timing monitor
  logic sck_p = 1'b0, cs_p = 1'b1;
  int t_rise = 0, t_fall = 0, t_csf = 0, t_csr = 0;
  int high_w = 0, setup_meas = 0, hold_meas = 0, idle_meas = 0;
  int max_low = 0, cs_rises = 0;
  bit armed_setup = 0, seen_fall = 0;

  always @(negedge clk) begin
    if (sck && !sck_p) begin
      t_rise = cyc;
      if (!cs_n && armed_setup) begin
        setup_meas = cyc - t_csf;
        armed_setup = 0;
      end
      if (!cs_n && seen_fall && (cyc - t_fall) > max_low) max_low = cyc - t_fall;
    end
    if (!sck && sck_p) begin
      high_w = cyc - t_rise;
      t_fall = cyc;
      seen_fall = 1;
    end
    if (!cs_n && cs_p) begin
      t_csf = cyc;
      armed_setup = 1;
      idle_meas = cyc - t_csr;
      seen_fall = 0;
    end
    if (cs_n && !cs_p) begin
      hold_meas = cyc - t_fall;
      t_csr = cyc;
      cs_rises++;
    end
    sck_p = sck;
    cs_p = cs_n;
  end

  task automatic reg_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic tx_byte(input logic [7:0] b, input bit accept);
    reg_write(6'h0C, {24'h0, b});
    if (accept) begin
      exp_mosi.push_back(b);
      exp_rx.push_back(resp(n_acc));
      n_acc++;
    end
  endtask

  task automatic drain(input int n);
    logic [31:0] v;
    logic [7:0] e;
    int got = 0;
    while (got < n) begin
      reg_read(6'h10, v);
      if (!v[31]) begin
        e = (exp_rx.size() > 0) ? exp_rx.pop_front() : 8'h00;
        check(v[7:0] == e && v[30:8] == '0, "R4 received byte in order", v, {24'h0, e});
        got++;
      end
    end
  endtask

  task automatic wait_done();
    while (cs_n) @(negedge clk);
    while (!cs_n) @(negedge clk);
    repeat (40) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R0 watchdog expired actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int c0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(cs_n == 1'b1 && sck == 1'b0 && irq == 1'b0, "R1 pins after reset",
          {29'h0, cs_n, sck, irq}, 32'h4);
    reg_read(6'h00, v); check(v == 32'd3, "R1 divider reset", v, 3);
    reg_read(6'h04, v); check(v == 32'h0101, "R1 select timing reset", v, 32'h0101);
    reg_read(6'h08, v); check(v == 32'h0001, "R1 frame spacing reset", v, 1);
    reg_read(6'h1C, v); check(v == 32'h0, "R1 enable mask reset", v, 0);
    reg_read(6'h20, v); check(v == 32'h0, "R1 pending reset", v, 0);

    // R10 / R12 watermark flags and masking
    reg_write(6'h14, 1);
    reg_write(6'h1C, 3);
    reg_read(6'h20, v); check(v == 32'h1, "R10 tx pending when empty below mark", v, 1);
    check(irq == 1'b1, "R12 irq with tx enabled", irq, 1);
    reg_write(6'h1C, 2);
    @(negedge clk);
    check(irq == 1'b0, "R12 irq masked off", irq, 0);

    // R5 empty receive read
    reg_read(6'h10, v); check(v == 32'h8000_0000, "R5 empty receive read", v, 32'h8000_0000);

    // three back-to-back bytes: divider 1, setup 2, hold 1
    reg_write(6'h00, 1);
    reg_write(6'h04, 32'h0102);
    reg_write(6'h18, 1);
    c0 = cs_rises;
    max_low = 0;
    tx_byte(8'hA5, 1);
    tx_byte(8'h3C, 1);
    tx_byte(8'hFF, 1);
    wait_done();
    check(setup_meas == 10, "R7 select to first edge", setup_meas, 10);
    check(high_w == 2, "R2 half period at divider 1", high_w, 2);
    check(cs_rises - c0 == 1, "R8 select held across frames", cs_rises - c0, 1);
    check(hold_meas == 4, "R8 hold after last edge", hold_meas, 4);
    check(max_low == 2, "R13 no pause when spacing zero", max_low, 2);
    reg_read(6'h20, v); check(v == 32'h3, "R11 rx pending above mark", v, 3);
    check(irq == 1'b1, "R12 irq with rx enabled", irq, 1);
    drain(3);
    reg_read(6'h20, v); check(v == 32'h1, "R11 rx pending cleared after drain", v, 1);
    reg_read(6'h10, v); check(v == 32'h8000_0000, "R5 empty after drain", v, 32'h8000_0000);

    // R13 pause of 2 periods between bytes
    reg_write(6'h08, 32'h0201);
    max_low = 0;
    tx_byte(8'h81, 1);
    tx_byte(8'h7E, 1);
    wait_done();
    check(max_low == 10, "R13 pause between bytes", max_low, 10);
    drain(2);

    // R9 deselect minimum of 3 periods
    reg_write(6'h08, 32'h0003);
    tx_byte(8'h12, 1);
    while (cs_n) @(negedge clk);
    while (!cs_n) @(negedge clk);
    tx_byte(8'h34, 1);
    wait_done();
    check(idle_meas >= 12 && idle_meas <= 14, "R9 deselect minimum", idle_meas, 13);
    drain(2);

    // R6 overflow at divider 20
    reg_write(6'h00, 20);
    reg_write(6'h04, 32'h0101);
    reg_write(6'h08, 32'h0001);
    reg_write(6'h18, 0);
    repeat (20) @(negedge clk);
    for (int i = 0; i < 9; i++) tx_byte(8'(8'h40 + i), 1);
    tx_byte(8'hEE, 0);
    reg_read(6'h0C, v); check(v[31] == 1'b1, "R6 full flag", v, 32'h8000_0000);
    reg_read(6'h20, v); check(v[0] == 1'b0, "R10 tx pending clear when full", v, 0);
    drain(9);
    check(high_w == 21, "R2 half period at divider 20", high_w, 21);
    wait_done();
    reg_read(6'h0C, v); check(v[31] == 1'b0, "R6 full flag clear", v, 0);
    check(exp_mosi.size() == 0 && s_k == n_acc, "R6 dropped write not sent", s_k, n_acc);
    reg_read(6'h10, v); check(v == 32'h8000_0000, "R5 nothing extra received", v, 32'h8000_0000);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule